// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block sits on the device side of a synchronous DRAM pin interface and turns WRITE commands into a stream of single-word writes for a memory array. It decodes the control strobes on each rising clock edge. When it sees a WRITE it latches the bank, the starting column and the auto-precharge flag. It takes the data word present with the command as the first word of the burst. After that it takes one more word on every following edge until the burst is done. Each accepted word leaves the block as a registered array write carrying bank, column and data.

Burst length comes from a static configuration input and is latched with each command. Fixed bursts of 1, 2, 4 or 8 words step the column through an aligned block and wrap inside it. A full-page burst steps through the whole row, wraps to column zero and only stops when a new command arrives. A new WRITE is accepted in any cycle and at once replaces the burst in progress. When auto precharge was requested and the burst runs to its end, a one-cycle precharge request names the bank whose row should close.

The controller has two states, `ST_IDLE` and `ST_BURST`, and four named transitions. *accept* moves IDLE to BURST on a WRITE longer than one word. A one-word WRITE stays in IDLE. *retarget* keeps BURST on a new WRITE that replaces the current burst. *advance* keeps BURST while words remain. *finish* moves BURST to IDLE after the last word of a fixed burst.

Top module: `sdram_wr_burst`

## Requirements
- R1: A WRITE is decoded only when `cke`=1, `cs_n`=0, `ras_n`=1, `cas_n`=0 and `we_n`=0 at a rising edge. Every other combination is a no-operation and produces no array write.
- R2: The data word on `dq` at the edge that registers a WRITE is the first burst word. One cycle later the block presents `mem_we`=1 with the command's bank, its start column and that data. After reset all outputs are 0.
- R3: Each following edge of a burst captures the next word. `burst_len` selects the burst: 0→1 word, 1→2, 2→4, 3→8, 7→full page, and 4, 5, 6 act as 1 word. For a fixed length L, word i is written to column (start & ~(L-1)) | ((start+i) & (L-1)).
- R4: After the last word of a fixed burst, while no new WRITE arrives, data on `dq` is ignored and `mem_we` stays 0.
- R5: A full-page burst writes column (start+i) mod 2^COL_W for word i and continues without limit until a new WRITE arrives.
- R6: A WRITE in any cycle of a burst ends that burst at once. Its same-cycle data is written to the new bank and column, with no idle cycle and any bank allowed.
- R7: Address bit 10 sampled with the WRITE requests auto precharge. If it is 1, `pre_req` pulses with `pre_bank` equal to the burst's bank in the same cycle as the last word's array write. If it is 0, `pre_req` stays 0.
- R8: A burst with auto precharge that is cut short by a new WRITE raises no precharge request.
- R9: `dqm`=1 in a burst cycle suppresses that word's array write. The column and the word count still advance, and the auto-precharge request still follows the last word.
- R10: The column is `addr[COL_W-1:0]` for COL_W up to 10, and {`addr[11]`, `addr[9:0]`} for COL_W=11. All other address bits are ignored for the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; commands are decoded only while high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| ba | input | BANK_W | Bank address |
| addr | input | ADDR_W | Address bus: column bits and the auto-precharge bit 10 |
| dq | input | DATA_W | Write data bus |
| dqm | input | 1 | Data mask; high blocks the array write for the current word |
| burst_len | input | 3 | Burst length code (see R3) |
| mem_we | output | 1 | Array write strobe |
| mem_bank | output | BANK_W | Array write bank |
| mem_col | output | COL_W | Array write column |
| mem_data | output | DATA_W | Array write data |
| pre_req | output | 1 | One-cycle request to precharge the open row |
| pre_bank | output | BANK_W | Bank to precharge |

## Verification
The assertions check on every cycle the following behaviours: the data and address of the first word taken with a command, the silence of the array port in idle, the masking of words by `dqm`, the persistence of full-page bursts, the single-word precharge, and the absence of a precharge after truncation. Some behaviours only the bench can show, because they need a whole burst to unfold. These are the exact column sequence inside aligned blocks for every length and start column, the wrap of a full-page burst past the last column, the timing of the precharge request on the last word, and the hand-over between back-to-back writes to different banks.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } wr_state_e;

    localparam logic [2:0] BL_CODE_FULL = 3'b111;

    // Words in a fixed burst for a length code; reserved codes act as one word.
    function automatic logic [3:0] bl_words(input logic [2:0] code);
        logic [3:0] n;
        case (code)
            3'd1:    n = 4'd2;
            3'd2:    n = 4'd4;
            3'd3:    n = 4'd8;
            default: n = 4'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/wr_cmd_decode.sv
module wr_cmd_decode #(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 9
) (
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_write,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap
);

    localparam int AP_BIT = 10;

    logic unused_addr;
    assign unused_addr = ^addr;

    assign is_write = cke && !cs_n && ras_n && !cas_n && !we_n;
    assign cmd_ap   = addr[AP_BIT];

    generate
        if (COL_W == 11) begin : g_col_wide
            assign cmd_col = {addr[11], addr[9:0]};
        end else begin : g_col_narrow
            assign cmd_col = addr[COL_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/wr_col_step.sv
module wr_col_step
    import sdram_wr_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] col,
    input  logic [2:0]       code,
    output logic [COL_W-1:0] nxt
);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] inc;

    assign inc = col + COL_W'(1);

    always_comb begin
        case (code)
            3'd1:         mask = COL_W'(1);
            3'd2:         mask = COL_W'(3);
            3'd3:         mask = COL_W'(7);
            BL_CODE_FULL: mask = '1;
            default:      mask = '0;
        endcase
    end

    assign nxt = (col & ~mask) | (inc & mask);

endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst
    import sdram_wr_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq,
    input  logic              dqm,
    input  logic [2:0]        burst_len,
    output logic              mem_we,
    output logic [BANK_W-1:0] mem_bank,
    output logic [COL_W-1:0]  mem_col,
    output logic [DATA_W-1:0] mem_data,
    output logic              pre_req,
    output logic [BANK_W-1:0] pre_bank
);

    localparam int LEFT_W = 4;

    wr_state_e         state_q, state_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic [COL_W-1:0]  col_q, col_d;
    logic [LEFT_W-1:0] left_q, left_d;
    logic [2:0]        code_q, code_d;
    logic              ap_q, ap_d;

    logic              is_write;
    logic [COL_W-1:0]  cmd_col;
    logic              cmd_ap;
    logic              cmd_single;
    logic              take_cmd;
    logic [COL_W-1:0]  step_in, step_out;
    logic [2:0]        step_code;

    logic              wr_d, pre_d;
    logic [BANK_W-1:0] wr_bank;
    logic [COL_W-1:0]  wr_col;

    wr_cmd_decode #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_dec (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .is_write(is_write), .cmd_col(cmd_col), .cmd_ap(cmd_ap)
    );

    assign cmd_single = (burst_len != BL_CODE_FULL) && (bl_words(burst_len) == 4'd1);
    assign step_in    = is_write ? cmd_col : col_q;
    assign step_code  = is_write ? burst_len : code_q;

    wr_col_step #(.COL_W(COL_W)) u_step (
        .col(step_in), .code(step_code), .nxt(step_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bank_q  <= '0;
            col_q   <= '0;
            left_q  <= '0;
            code_q  <= '0;
            ap_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
            col_q   <= col_d;
            left_q  <= left_d;
            code_q  <= code_d;
            ap_q    <= ap_d;
        end
    end

    // Next state and array-port request
    always_comb begin
        state_d  = state_q;
        bank_d   = bank_q;
        col_d    = col_q;
        left_d   = left_q;
        code_d   = code_q;
        ap_d     = ap_q;
        take_cmd = 1'b0;
        wr_d     = 1'b0;
        pre_d    = 1'b0;
        wr_bank  = bank_q;
        wr_col   = col_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_write) take_cmd = 1'b1;              // accept
            end
            ST_BURST: begin
                if (is_write) begin
                    take_cmd = 1'b1;                        // retarget
                end else begin
                    wr_d  = !dqm;                           // advance
                    col_d = step_out;
                    if (code_q != BL_CODE_FULL) begin
                        left_d = left_q - LEFT_W'(1);
                        if (left_q == LEFT_W'(1)) begin     // finish
                            state_d = ST_IDLE;
                            pre_d   = ap_q;
                        end
                    end
                end
            end
        endcase
        if (take_cmd) begin
            wr_d    = !dqm;
            wr_bank = ba;
            wr_col  = cmd_col;
            bank_d  = ba;
            ap_d    = cmd_ap;
            code_d  = burst_len;
            col_d   = step_out;
            if (burst_len == BL_CODE_FULL) begin
                state_d = ST_BURST;
                left_d  = '0;
            end else if (cmd_single) begin
                state_d = ST_IDLE;
                left_d  = '0;
                pre_d   = cmd_ap;
            end else begin
                state_d = ST_BURST;
                left_d  = bl_words(burst_len) - LEFT_W'(1);
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we   <= 1'b0;
            mem_bank <= '0;
            mem_col  <= '0;
            mem_data <= '0;
            pre_req  <= 1'b0;
            pre_bank <= '0;
        end else begin
            mem_we   <= wr_d;
            mem_bank <= wr_bank;
            mem_col  <= wr_col;
            mem_data <= dq;
            pre_req  <= pre_d;
            pre_bank <= wr_bank;
        end
    end

    // R2: word taken with the command reaches the array port one cycle later
    p_cmd_first_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_write && !dqm) |=> (mem_we && mem_bank == $past(ba)
                                && mem_col == $past(cmd_col) && mem_data == $past(dq)));

    // R4: idle with no command writes nothing and requests nothing
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !is_write) |=> (!mem_we && !pre_req));

    // R5: a full-page burst never leaves the burst state on its own
    p_full_page_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && code_q == BL_CODE_FULL && !is_write) |=> (state_q == ST_BURST));

    // R7: a one-word write with auto precharge requests precharge of its bank
    p_single_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_write && cmd_single && cmd_ap) |=> (pre_req && pre_bank == $past(ba)));

    // R8: truncating a burst never produces a precharge request
    p_trunc_no_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && is_write && !cmd_single) |=> !pre_req);

    // R9: a masked word produces no array write
    p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_write || state_q == ST_BURST) && dqm) |=> !mem_we);

endmodule

// File: tb/test_sdram_wr_burst.sv
module test_sdram_wr_burst;

    localparam int CLK_PERIOD = 10;
    localparam int BANK_W = 2;
    localparam int COL_W  = 4;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BANK_W-1:0] ba = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] dq = '0;
    logic              dqm = 1'b0;
    logic [2:0]        burst_len = '0;
    logic              mem_we, pre_req;
    logic [BANK_W-1:0] mem_bank, pre_bank;
    logic [COL_W-1:0]  mem_col;
    logic [DATA_W-1:0] mem_data;

    int tests = 0;
    int fails = 0;
    int seed  = 1;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_wr_burst #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_sdram_wr_burst (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .dq(dq), .dqm(dqm), .burst_len(burst_len),
        .mem_we(mem_we), .mem_bank(mem_bank), .mem_col(mem_col), .mem_data(mem_data),
        .pre_req(pre_req), .pre_bank(pre_bank)
    );

    task automatic check(input string tag, input logic we_e, input logic [COL_W-1:0] col_e,
                         input logic [BANK_W-1:0] bank_e, input logic [DATA_W-1:0] d_e,
                         input logic pre_e);
        bit bad;
        bad = (mem_we !== we_e) || (pre_req !== pre_e);
        if (we_e && (mem_col !== col_e || mem_bank !== bank_e || mem_data !== d_e)) bad = 1'b1;
        if (pre_e && pre_bank !== bank_e) bad = 1'b1;
        tests++;
        if (bad) begin
            fails++;
            $display("FAIL %s: got we=%0b bank=%0d col=%0d data=%h pre=%0b/%0d, expected we=%0b bank=%0d col=%0d data=%h pre=%0b",
                     tag, mem_we, mem_bank, mem_col, mem_data, pre_req, pre_bank,
                     we_e, bank_e, col_e, d_e, pre_e);
        end
    endtask

    // Drive one cycle at the falling edge; sample a quarter period after the rising edge.
    task automatic drive(input logic c_cke, input logic c_cs, input logic c_ras, input logic c_cas,
                         input logic c_we, input logic [BANK_W-1:0] b, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input logic m, input logic [2:0] code);
        @(negedge clk);
        cke = c_cke; cs_n = c_cs; ras_n = c_ras; cas_n = c_cas; we_n = c_we;
        ba = b; addr = a; dq = d; dqm = m; burst_len = code;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    // One WRITE followed by n_drive-1 NOP cycles with data, checked each cycle.
    task automatic burst(input string tag, input logic [BANK_W-1:0] b, input logic [COL_W-1:0] col,
                         input logic ap, input logic [2:0] code, input int n_drive, input int mask_idx);
        bit full;
        int bl;
        full = (code == 3'd7);
        bl   = (code < 3'd4) ? (1 << code) : 1;
        for (int i = 0; i < n_drive; i++) begin
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            logic [COL_W-1:0]  ce;
            logic              act;
            a  = {2'b11, ap, 6'h2A, col};
            d  = DATA_W'(seed * 37 + i * 5 + 16'h1200);
            if (i == 0) drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, b, a, d, (i == mask_idx), code);
            else        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, ~b, ~a, d, (i == mask_idx), code);
            act = full || (i < bl);
            if (full) ce = COL_W'(col + i);
            else      ce = (col & ~COL_W'(bl - 1)) | (COL_W'(col + i) & COL_W'(bl - 1));
            check(tag, act && (i != mask_idx), ce, b, d, !full && ap && (i == bl - 1));
        end
        seed++;
    endtask

    task automatic nop_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0, 16'hDEAD, 1'b0, 3'd0);
            check("R4 idle", 1'b0, '0, '0, '0, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 3 + 2);
        // R2: reset state
        check("R2 reset", 1'b0, '0, '0, '0, 1'b0);
        tests++;
        if (mem_bank !== '0 || mem_col !== '0 || mem_data !== '0 || pre_bank !== '0) begin
            fails++;
            $display("FAIL R2 reset: got bank=%0d col=%0d data=%h pre_bank=%0d, expected all 0",
                     mem_bank, mem_col, mem_data, pre_bank);
        end
        rst_n = 1'b1;
        nop_cycles(2);

        // R1: every strobe combination other than the WRITE is a no-operation
        for (int k = 0; k < 32; k++) begin
            logic [4:0] s;
            s = 5'(k);
            if (s == 5'b10100) continue;
            drive(s[4], s[3], s[2], s[1], s[0], 2'd1, 13'h0405, 16'hBEEF, 1'b0, 3'd0);
            check("R1 non-write", 1'b0, '0, '0, '0, 1'b0);
        end
        burst("R1 write", 2'd2, 4'd6, 1'b0, 3'd0, 2, -1);

        // R3/R4/R7/R10: all fixed lengths, start columns, precharge flags
        for (int code = 0; code < 4; code++)
            for (int col = 0; col < 16; col++)
                for (int ap = 0; ap < 2; ap++)
                    burst("R3/R4/R7/R10 sweep", 2'(col + code), 4'(col), ap[0], 3'(code),
                          (1 << code) + 2, -1);

        // R3: reserved codes act as one word
        for (int code = 4; code < 7; code++)
            burst("R3 reserved", 2'd3, 4'd9, 1'b1, 3'(code), 3, -1);

        // R5: full page wraps and keeps going; R6: a new write ends it
        burst("R5 full page", 2'd1, 4'd13, 1'b1, 3'd7, 20, -1);
        burst("R6 after full page", 2'd2, 4'd5, 1'b0, 3'd1, 3, -1);

        // R8: precharge burst truncated; R6: new write takes over
        burst("R8 truncated", 2'd1, 4'd2, 1'b1, 3'd3, 3, -1);
        burst("R6 takeover", 2'd3, 4'd9, 1'b1, 3'd2, 6, -1);

        // R6: back-to-back commands to changing banks
        for (int k = 0; k < 6; k++)
            burst("R6 back-to-back", 2'(k), 4'(k * 3), 1'b1, 3'd3, 1, -1);
        burst("R6 last of chain", 2'd2, 4'd11, 1'b1, 3'd3, 10, -1);

        // R9: masked words at first, middle and last positions
        burst("R9 mask first", 2'd0, 4'd4, 1'b0, 3'd3, 9, 0);
        burst("R9 mask middle", 2'd1, 4'd4, 1'b1, 3'd3, 9, 3);
        burst("R9 mask last", 2'd2, 4'd12, 1'b1, 3'd3, 9, 7);
        burst("R9 mask single", 2'd3, 4'd1, 1'b1, 3'd0, 2, 0);
        nop_cycles(3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule